// File: doc/BRIEF.md
# Interrupt Flag and Vectoring Controller

This block collects the interrupt sources of a small 8-bit processor core and turns them into a request, a vector fetch and a wake signal. There are four sources. An external pin is watched for one chosen edge. A timer-overflow pulse comes in from the timer. A port of general-purpose pins is compared against a reference value, and each pin has its own enable. A converter-done pulse comes in from the converter. Every source owns a sticky flag bit and an enable bit. The processor reads and writes these bits through a small register port, and only software can clear a flag.

The block also keeps the four-phase count of an instruction cycle. When a request is accepted, it inserts one empty instruction cycle. It then pulses a program-counter load with the fixed vector address 0004h and drops the global enable at the same moment. A return-from-interrupt pulse sets the global enable again. While the core sleeps, no vector is taken. The wake output rises as soon as any enabled flag is pending, whatever the global enable holds.

Top module: `irqc_top`

## Requirements
- R1: While reset is held low, every register reads 0 and irq, wake, vec_dummy, pc_load and q_phase are all 0.
- R2: The external pin's edge sets the control-register bit 1 (ext flag) after a two-flop synchronizer, and only during phase Q4 or Q1. The option register (address 1) bit 6 chooses the edge: 1 selects rising, 0 selects falling. The other edge leaves the flag clear.
- R3: A one-clock timer-overflow pulse sets control bit 2 at the next clock edge. Control bit 5 is the enable for this flag.
- R4: Control bit 0 is the change flag and control bit 3 is its enable. The synchronized port is compared with a reference value. Any difference on a pin whose bit is set in the change-enable register (address 2) sets bit 0 and keeps setting it. A port read (address 5) loads the reference with the current pins and returns them. Differences on pins that are not enabled are ignored.
- R5: A converter-done pulse sets bit 6 of the peripheral flag register (address 3). Bit 6 of the peripheral enable register (address 4) enables it, and control bit 6 must also be set as the group enable.
- R6: Flags are never cleared by hardware. A write clears them. When a hardware set and a write of 0 fall in the same clock, the set wins.
- R7: irq is high exactly when control bit 7 (global enable) is 1 and at least one enabled flag is set.
- R8: While sleep is high, wake follows the enabled-and-pending condition and ignores bit 7, and no vector sequence starts. The vector sequence starts once sleep is low.
- R9: A request seen at a Q4 edge starts one dummy instruction cycle, with vec_dummy high for 4 clocks. pc_load is then high for one clock in Q1, with pc_vector = 0004h. A timer pulse driven during Q1 reaches pc_load 8 clocks later.
- R10: Control bit 7 is cleared when the vector sequence starts, and set by a reti pulse.
- R11: q_phase counts 0,1,2,3 (Q1..Q4) and wraps, one step per clock, starting at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer wrap pulse, one clock |
| port_pins | input | PORT_W | Asynchronous general-purpose pins |
| adc_done | input | 1 | Converter completion pulse, one clock |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| sleeping | input | 1 | Core is in sleep |
| reti | input | 1 | Return-from-interrupt pulse |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake request to a sleeping core |
| q_phase | output | 2 | Current phase, 0 = Q1 |
| vec_dummy | output | 1 | Dummy instruction cycle in progress |
| pc_load | output | 1 | Load program counter with pc_vector |
| pc_vector | output | PC_W | Vector address |

## Verification
The bench sends a timer pulse in a known phase and counts the clocks until pc_load. A sequencer that skipped the dummy cycle, or sampled the request at the wrong phase, would show a latency other than 8 or a dummy window other than 4 clocks. It issues a write of 0 and a timer pulse in the same clock, which catches a design that lets software beat hardware. On the port it checks that the flag keeps coming back until the pins are read, and that disabled pins stay silent. A reference that never updated, or a missing mask, would show up there. It also raises a flag while sleep is high with global enable clear, and then with it set. A design that gated wake on the global enable, or vectored during sleep, fails those checks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register map of the controller
    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_OPT   = 3'd1,
        A_CHGEN = 3'd2,
        A_PFLAG = 3'd3,
        A_PEN   = 3'd4,
        A_PORT  = 3'd5
    } reg_addr_e;

    // Bit positions in the control register
    localparam int B_CHG_F = 0;
    localparam int B_EXT_F = 1;
    localparam int B_TMR_F = 2;
    localparam int B_CHG_E = 3;
    localparam int B_EXT_E = 4;
    localparam int B_TMR_E = 5;
    localparam int B_PER_E = 6;
    localparam int B_GLB_E = 7;

    // Bit positions in option and peripheral registers
    localparam int B_EDGE_SEL = 6;
    localparam int B_ADC      = 6;

    typedef enum logic [1:0] {Q1 = 2'd0, Q2 = 2'd1, Q3 = 2'd2, Q4 = 2'd3} qphase_e;

    typedef enum logic [1:0] {V_IDLE = 2'd0, V_DUMMY = 2'd1, V_LOAD = 2'd2} vec_state_e;

endpackage

// File: rtl/irqc_sync.sv
// Two-flop synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no bus coherence is given.
module irqc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/irqc_ext_edge.sv
// Detects the selected edge on the synchronized external pin and holds it
// pending until the phase window Q4/Q1 in which the flag may be set.
// Assumes pin_s is already synchronized to clk.
module irqc_ext_edge
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_s,
    input  logic       rise_sel,
    input  logic [1:0] q_phase,
    output logic       set_flag
);
    logic prev_q;
    logic pend_q;
    logic edge_hit;
    logic in_window;

    assign edge_hit  = rise_sel ? (pin_s & ~prev_q) : (~pin_s & prev_q);
    assign in_window = (q_phase == Q4) || (q_phase == Q1);
    assign set_flag  = pend_q & in_window;

    // Remember last pin level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Hold a detected edge until the flag window opens
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (edge_hit) pend_q <= 1'b1;
        else if (set_flag) pend_q <= 1'b0;
    end

    // R2: a pending edge is consumed in the window, never lost outside it
    p_pend_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !in_window) |=> pend_q);
endmodule

// File: rtl/irqc_port_change.sv
// Compares the synchronized port against a reference captured on every
// port read and reports a difference on any enabled pin. A difference
// arising in the read cycle itself is absorbed by the reload (allowed miss).
module irqc_port_change #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_s,
    input  logic [W-1:0] chg_en,
    input  logic         port_rd,
    output logic         set_flag
);
    logic [W-1:0] ref_q;
    logic [W-1:0] diff;

    assign diff     = (pins_s ^ ref_q) & chg_en;
    assign set_flag = (|diff) & ~port_rd;

    // Reload the comparison reference whenever the port is read
    always_ff @(posedge clk) begin
        if (!rst_n)       ref_q <= '0;
        else if (port_rd) ref_q <= pins_s;
    end

    // R4: right after a read, unchanged pins raise no change
    p_quiet_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(port_rd) && $stable(pins_s) && !port_rd) |-> !set_flag);
endmodule

// File: rtl/irqc_vec_seq.sv
// Four-phase instruction-cycle counter and vector sequencer. A request seen
// at a Q4 edge inserts one dummy instruction cycle, then pulses pc_load in
// Q1 of the following cycle. Assumes req is stable over a clock.
module irqc_vec_seq
    import irqc_pkg::*;
#(
    parameter int PC_W     = 13,
    parameter int VEC_ADDR = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            sleeping,
    output logic [1:0]      q_phase,
    output logic            vec_take,
    output logic            vec_dummy,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_vector
);
    qphase_e    q_q;
    vec_state_e st_q, st_d;
    logic       last_phase;

    assign q_phase    = q_q;
    assign last_phase = (q_q == Q4);
    assign vec_take   = (st_q == V_IDLE) && last_phase && req && !sleeping;
    assign vec_dummy  = (st_q == V_DUMMY);
    assign pc_load    = (st_q == V_LOAD) && (q_q == Q1);
    assign pc_vector  = PC_W'(VEC_ADDR);

    // Advance the phase counter every clock
    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= Q1;
        else        q_q <= qphase_e'(q_q + 2'd1);
    end

    // Next vector state, moving only on instruction-cycle boundaries
    always_comb begin
        st_d = st_q;
        case (st_q)
            V_IDLE:  if (vec_take)   st_d = V_DUMMY;
            V_DUMMY: if (last_phase) st_d = V_LOAD;
            V_LOAD:  if (last_phase) st_d = V_IDLE;
            default: st_d = V_IDLE;
        endcase
    end

    // Vector state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= V_IDLE;
        else        st_q <= st_d;
    end

    // R11: phase advances by one each clock
    p_phase_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (q_phase == 2'($past(q_phase) + 2'd1)));
    // R9: load comes in Q1 right after the dummy cycle
    p_load_after_dummy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (q_phase == 2'd0) && $past(vec_dummy));
    // R9: dummy cycle starts in Q1
    p_dummy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_dummy) |-> (q_phase == 2'd0));
    // R8: no vector starts while asleep
    p_no_vec_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && !vec_dummy && !pc_load) |=> !vec_dummy);
endmodule

// File: rtl/irqc_top.sv
// Interrupt flag controller: register file with sticky flags, source
// detectors, request/wake generation and the vector sequencer.
// Assumes tmr_ovf and adc_done are synchronous one-clock pulses and that
// ext_pin and port_pins are asynchronous.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int PORT_W   = 6,
    parameter int PC_W     = 13,
    parameter int VEC_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              tmr_ovf,
    input  logic [PORT_W-1:0] port_pins,
    input  logic              adc_done,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sleeping,
    input  logic              reti,
    output logic              irq,
    output logic              wake,
    output logic [1:0]        q_phase,
    output logic              vec_dummy,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_vector
);
    localparam int SYNC_W = PORT_W + 1;

    logic [7:0]        ctrl_q, ctrl_d;
    logic              edge_sel_q;
    logic [PORT_W-1:0] chg_en_q;
    logic              pflag_q, pen_q;
    logic [SYNC_W-1:0] sync_out;
    logic              ext_s;
    logic [PORT_W-1:0] pins_s;
    logic              ext_set, chg_set, vec_take, src_pend, port_rd;
    logic              wr_ctrl, wr_opt, wr_chgen, wr_pflag, wr_pen;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_opt   = reg_we && (reg_addr == A_OPT);
    assign wr_chgen = reg_we && (reg_addr == A_CHGEN);
    assign wr_pflag = reg_we && (reg_addr == A_PFLAG);
    assign wr_pen   = reg_we && (reg_addr == A_PEN);
    assign port_rd  = reg_re && (reg_addr == A_PORT);

    irqc_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_pin, port_pins}),
        .q_sync  (sync_out)
    );
    assign ext_s  = sync_out[SYNC_W-1];
    assign pins_s = sync_out[PORT_W-1:0];

    irqc_ext_edge u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (ext_s),
        .rise_sel (edge_sel_q),
        .q_phase  (q_phase),
        .set_flag (ext_set)
    );

    irqc_port_change #(.W(PORT_W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_s   (pins_s),
        .chg_en   (chg_en_q),
        .port_rd  (port_rd),
        .set_flag (chg_set)
    );

    irqc_vec_seq #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq),
        .sleeping  (sleeping),
        .q_phase   (q_phase),
        .vec_take  (vec_take),
        .vec_dummy (vec_dummy),
        .pc_load   (pc_load),
        .pc_vector (pc_vector)
    );

    // Any source with its flag and enable(s) set
    assign src_pend = (ctrl_q[B_CHG_F] & ctrl_q[B_CHG_E])
                    | (ctrl_q[B_EXT_F] & ctrl_q[B_EXT_E])
                    | (ctrl_q[B_TMR_F] & ctrl_q[B_TMR_E])
                    | (pflag_q & pen_q & ctrl_q[B_PER_E]);
    assign irq  = ctrl_q[B_GLB_E] & src_pend;
    assign wake = sleeping & src_pend;

    // Control register next value: software write, then hardware overrides
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl)  ctrl_d = reg_wdata;
        if (reti)     ctrl_d[B_GLB_E] = 1'b1;
        if (vec_take) ctrl_d[B_GLB_E] = 1'b0;
        if (chg_set)  ctrl_d[B_CHG_F] = 1'b1;
        if (ext_set)  ctrl_d[B_EXT_F] = 1'b1;
        if (tmr_ovf)  ctrl_d[B_TMR_F] = 1'b1;
    end

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Option, change-enable and peripheral enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_sel_q <= 1'b0;
            chg_en_q   <= '0;
            pen_q      <= 1'b0;
        end else begin
            if (wr_opt)   edge_sel_q <= reg_wdata[B_EDGE_SEL];
            if (wr_chgen) chg_en_q   <= reg_wdata[PORT_W-1:0];
            if (wr_pen)   pen_q      <= reg_wdata[B_ADC];
        end
    end

    // Peripheral flag: converter set wins over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)        pflag_q <= 1'b0;
        else if (adc_done) pflag_q <= 1'b1;
        else if (wr_pflag) pflag_q <= reg_wdata[B_ADC];
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_OPT:   reg_rdata[B_EDGE_SEL] = edge_sel_q;
            A_CHGEN: reg_rdata[PORT_W-1:0] = chg_en_q;
            A_PFLAG: reg_rdata[B_ADC] = pflag_q;
            A_PEN:   reg_rdata[B_ADC] = pen_q;
            A_PORT:  reg_rdata[PORT_W-1:0] = pins_s;
            default: reg_rdata = '0;
        endcase
    end

    // R6: flags stay set unless software writes the control register
    p_flags_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ((ctrl_q[2:0] & $past(ctrl_q[2:0])) == $past(ctrl_q[2:0])));
    // R7: no request without global enable
    p_irq_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q[B_GLB_E]);
    // R10: global enable is off once the dummy cycle begins
    p_gie_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_dummy) |-> !ctrl_q[B_GLB_E]);
    // R2: ext flag rises only through a write or in the Q4/Q1 window
    p_ext_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q[B_EXT_F]) && !$past(wr_ctrl)) |->
            ($past(q_phase) == 2'd3 || $past(q_phase) == 2'd0));
    // R8: a pending external source wakes regardless of global enable
    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && ctrl_q[B_EXT_F] && ctrl_q[B_EXT_E]) |-> wake);
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
    localparam int PORT_W = 6;
    localparam int PC_W   = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_pin = 1'b0;
    logic              tmr_ovf = 1'b0;
    logic [PORT_W-1:0] port_pins = '0;
    logic              adc_done = 1'b0;
    logic              reg_we = 1'b0;
    logic              reg_re = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              sleeping = 1'b0;
    logic              reti = 1'b0;
    logic              irq, wake, vec_dummy, pc_load;
    logic [1:0]        q_phase;
    logic [PC_W-1:0]   pc_vector;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_top #(.PORT_W(PORT_W), .PC_W(PC_W), .VEC_ADDR(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_pins(port_pins), .adc_done(adc_done), .reg_we(reg_we),
        .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleeping(sleeping), .reti(reti), .irq(irq),
        .wake(wake), .q_phase(q_phase), .vec_dummy(vec_dummy),
        .pc_load(pc_load), .pc_vector(pc_vector)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk("R1 q_phase", int'(q_phase), 0);
        chk("R1 irq/wake/dummy/load", int'({irq, wake, vec_dummy, pc_load}), 0);
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 register", int'(d), 0);
        end
    endtask

    task automatic t_ext_edge();
        logic [7:0] d;
        wr(3'd1, 8'h40);                       // rising selected
        ext_pin = 1'b1; idle(12);
        rd(3'd0, d); chk("R2 rising sets bit1", int'(d[1]), 1);
        wr(3'd0, 8'h00);
        ext_pin = 1'b0; idle(12);
        rd(3'd0, d); chk("R2 falling ignored when rising", int'(d[1]), 0);
        wr(3'd1, 8'h00);                       // falling selected
        ext_pin = 1'b1; idle(12);
        rd(3'd0, d); chk("R2 rising ignored when falling", int'(d[1]), 0);
        ext_pin = 1'b0; idle(12);
        rd(3'd0, d); chk("R2 falling sets bit1", int'(d[1]), 1);
        wr(3'd0, 8'h00);
        rd(3'd1, d); chk("R2 option bit6 readback", int'(d), 0);
    endtask

    task automatic t_timer_and_priority();
        logic [7:0] d;
        @(negedge clk); tmr_ovf = 1'b1;
        @(negedge clk); tmr_ovf = 1'b0;
        rd(3'd0, d); chk("R3 timer flag bit2", int'(d), 8'h04);
        wr(3'd0, 8'h00);
        rd(3'd0, d); chk("R6 software clears flag", int'(d), 0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; tmr_ovf = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tmr_ovf = 1'b0;
        rd(3'd0, d); chk("R6 hardware set beats write of 0", int'(d[2]), 1);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_port();
        logic [7:0] d;
        wr(3'd2, 8'h05);                       // pins 0 and 2 enabled
        port_pins = 6'h02; idle(6);
        rd(3'd0, d); chk("R4 disabled pin ignored", int'(d[0]), 0);
        port_pins = 6'h03; idle(6);
        rd(3'd0, d); chk("R4 enabled pin sets bit0", int'(d[0]), 1);
        wr(3'd0, 8'h00); idle(2);
        rd(3'd0, d); chk("R4 flag returns until port read", int'(d[0]), 1);
        rd(3'd5, d); chk("R4 port read value", int'(d), 8'h03);
        wr(3'd0, 8'h00); idle(4);
        rd(3'd0, d); chk("R4 quiet after port read", int'(d[0]), 0);
        port_pins = 6'h00; idle(6);
        rd(3'd5, d);
        wr(3'd0, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_periph();
        logic [7:0] d;
        wr(3'd4, 8'h40); wr(3'd0, 8'h40);
        sleeping = 1'b1;
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        rd(3'd3, d); chk("R5 converter flag bit6", int'(d), 8'h40);
        chk("R5 wake with group enable", int'(wake), 1);
        wr(3'd0, 8'h00);
        chk("R5 no wake without group enable", int'(wake), 0);
        wr(3'd3, 8'h00);
        rd(3'd3, d); chk("R5 flag cleared by write", int'(d), 0);
        wr(3'd4, 8'h00);
        sleeping = 1'b0;
    endtask

    task automatic t_sleep_wake();
        logic [7:0] d;
        int seen_dummy = 0;
        int seen_load = 0;
        wr(3'd1, 8'h40); wr(3'd0, 8'h10);
        sleeping = 1'b1;
        ext_pin = 1'b1; idle(12);
        chk("R8 wake with gie clear", int'(wake), 1);
        chk("R7 no irq with gie clear", int'(irq), 0);
        wr(3'd0, 8'h92);
        chk("R7 irq with gie set", int'(irq), 1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (vec_dummy) seen_dummy++;
        end
        chk("R8 no vector while asleep", seen_dummy, 0);
        sleeping = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (pc_load) seen_load++;
        end
        chk("R8 vector after sleep ends", seen_load, 1);
        wr(3'd0, 8'h00);
        ext_pin = 1'b0; idle(12);
        rd(3'd0, d); chk("R7 all clear", int'(d), 0);
    endtask

    task automatic t_vector();
        logic [7:0] d;
        int n = 0;
        int dummies = 0;
        wr(3'd0, 8'hA0);
        do @(negedge clk); while (q_phase != 2'd0);
        tmr_ovf = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk); tmr_ovf = 1'b0;
        while (!pc_load && n < 40) begin
            if (vec_dummy) dummies++;
            @(posedge clk); n++;
            @(negedge clk);
        end
        chk("R9 latency in clocks", n, 8);
        chk("R9 dummy cycle length", dummies, 4);
        chk("R9 load in Q1", int'(q_phase), 0);
        chk("R9 vector address", int'(pc_vector), 4);
        rd(3'd0, d);
        chk("R10 gie cleared by vector", int'(d), 8'h24);
        wr(3'd0, 8'h04);
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
        rd(3'd0, d); chk("R10 reti sets gie", int'(d), 8'h84);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_phase();
        int bad = 0;
        logic [1:0] prev;
        @(negedge clk); prev = q_phase;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (q_phase != 2'(prev + 2'd1)) bad++;
            prev = q_phase;
        end
        chk("R11 phase steps", bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        t_reset();
        t_phase();
        t_ext_edge();
        t_timer_and_priority();
        t_port();
        t_periph();
        t_sleep_wake();
        t_vector();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule